// File: doc/BRIEF.md
# Frame-Synchronous Time Slot Interchanger

This block regroups byte-interleaved traffic from four synchronous streams. Each stream carries twelve byte slots per frame, one byte per clock. All streams are frequency locked and share one frame pulse, which marks slot 0. Every output stream, in every slot, may take its byte from any input stream and any slot of the previous frame. A single source byte may feed any number of output positions, so the switch never blocks. The block does no pointer processing. Upstream logic must lock the streams and roughly align their frames.

The connections are held in four connection images. One image at a time steers the data path. Any image may be written at any time through a simple write port, and a write to an image that is not active leaves the traffic untouched. A swap command names an image and stays pending until the next frame pulse. At that pulse the named image takes over, starting from slot 0, so no frame is ever split between two maps. The byte store is double-buffered by frame: the frame being written never overlaps the frame being read. An output position that has no source, whose entry points past the last slot, or whose source input is flagged as failed carries path AIS, modelled as an all-ones byte.

Top module: `tsi_frame_switch`

## Requirements
- R1: A cycle with `frame_i` high is slot 0. Each following cycle is the next slot, wrapping from 11 to 0. A frame pulse that arrives early restarts the count at 0 and starts a new frame bank.
- R2: The byte on lane o of `dout_o` (bits 8o+7..8o) in the cycle after slot s of frame k+1 equals the byte that the mapped input lane of `din_i` (bits 8i+7..8i) carried in the mapped slot of frame k. `frame_o` is `frame_i` delayed by one cycle.
- R3: One source byte may feed several output lanes and slots in the same frame, and every one of them carries that byte.
- R4: An image entry is 7 bits: bit 6 is valid, bits 5:4 the source input and bits 3:0 the source slot. An entry with valid 0 yields 8'hFF.
- R5: A valid entry whose source slot is 12 or more yields 8'hFF.
- R6: If `fail_i` bit i is high in the cycle a slot is read from input i, that output byte is 8'hFF.
- R7: A write of `cfg_entry_i` to image `cfg_img_i`, output lane `cfg_port_i` and slot `cfg_slot_i` never changes the output while that image is not active. A write to the active image is used from the next read of that slot. Writes to slot 12 or above are ignored.
- R8: `swap_req_i` sets `swap_pending_o` in the next cycle. At the next `frame_i` cycle after that, the image given by `swap_img_i` steers slot 0 onward, `active_img_o` shows it, and `swap_pending_o` clears.
- R9: `active_img_o` changes only in the cycle after a frame pulse with a swap pending. A request made in the same cycle as a frame pulse waits for the following pulse.
- R10: After reset the active image is 0, no swap is pending, every image entry is invalid, every stored byte is 8'hFF, all output lanes are 8'hFF and `frame_o` is 0.
- R11: A new swap request made while one is pending replaces the target image.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one slot per cycle |
| rst | input | 1 | Synchronous active-high reset |
| frame_i | input | 1 | Frame pulse, marks slot 0 |
| din_i | input | 32 | Four input byte lanes |
| fail_i | input | 4 | Per-input failed or undriven flag |
| cfg_we_i | input | 1 | Image entry write strobe |
| cfg_img_i | input | 2 | Image to write |
| cfg_port_i | input | 2 | Output lane of the entry |
| cfg_slot_i | input | 4 | Output slot of the entry |
| cfg_entry_i | input | 7 | Entry {valid, source input, source slot} |
| swap_req_i | input | 1 | Request to activate an image |
| swap_img_i | input | 2 | Image to activate |
| frame_o | output | 1 | Frame pulse aligned to the output |
| dout_o | output | 32 | Four output byte lanes |
| active_img_o | output | 2 | Image currently steering the data path |
| swap_pending_o | output | 1 | A swap waits for the frame pulse |

## Verification
A corrupted byte bank or a wrong bank select shows up as wrong bytes on `dout_o` one cycle after the affected slot. It appears in the frame after the bad write. A wrong image entry, or a wrong choice of active image, shows up within one frame on the first lane and slot that reads it. A wrong pending flag shows up as a swap one frame early or late, seen at once on `active_img_o` and on the data. The reference model predicts every output each clock, so the first bad byte is caught in the cycle it appears.

// File: rtl/tsi_pkg.sv
package tsi_pkg;

    localparam int N_IN    = 4;
    localparam int N_SLOT  = 12;
    localparam int N_IMG   = 4;
    localparam int DW      = 8;
    localparam int IN_W    = $clog2(N_IN);
    localparam int SLOT_W  = $clog2(N_SLOT);
    localparam int IMG_W   = $clog2(N_IMG);
    localparam int N_BANK  = 2;

    typedef logic [DW-1:0] byte_t;

    typedef struct packed {
        logic              valid;
        logic [IN_W-1:0]   src_in;
        logic [SLOT_W-1:0] src_slot;
    } conn_t;

    localparam int ENTRY_W = $bits(conn_t);

    localparam byte_t AIS_BYTE = '1;

    function automatic logic entry_usable(conn_t e);
        return e.valid && (e.src_slot < SLOT_W'(N_SLOT));
    endfunction

    function automatic logic slot_in_range(logic [SLOT_W-1:0] s);
        return s < SLOT_W'(N_SLOT);
    endfunction

endpackage

// File: rtl/tsi_slot_timer.sv
module tsi_slot_timer
    import tsi_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_i,
    output logic [SLOT_W-1:0] cur_slot_o,
    output logic              cur_bank_o
);

    logic [SLOT_W-1:0] slot_q;
    logic              bank_q;

    always_comb begin
        if (frame_i) begin
            cur_slot_o = '0;
            cur_bank_o = ~bank_q;
        end else begin
            cur_slot_o = (slot_q == SLOT_W'(N_SLOT - 1)) ? '0 : slot_q + 1'b1;
            cur_bank_o = bank_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_q <= SLOT_W'(N_SLOT - 1);
            bank_q <= 1'b0;
        end else begin
            slot_q <= cur_slot_o;
            bank_q <= cur_bank_o;
        end
    end

endmodule

// File: rtl/tsi_data_store.sv
module tsi_data_store
    import tsi_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_bank_i,
    input  logic [SLOT_W-1:0]        wr_slot_i,
    input  logic [N_IN*DW-1:0]       din_i,
    input  logic [N_IN*IN_W-1:0]     rd_in_i,
    input  logic [N_IN*SLOT_W-1:0]   rd_slot_i,
    output logic [N_IN*DW-1:0]       rd_data_o
);

    byte_t mem [N_BANK][N_IN][N_SLOT];
    logic  rd_bank;

    assign rd_bank = ~wr_bank_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int b = 0; b < N_BANK; b++) begin
                for (int i = 0; i < N_IN; i++) begin
                    for (int s = 0; s < N_SLOT; s++) begin
                        mem[b][i][s] <= AIS_BYTE;
                    end
                end
            end
        end else if (slot_in_range(wr_slot_i)) begin
            for (int i = 0; i < N_IN; i++) begin
                mem[wr_bank_i][i][wr_slot_i] <= din_i[i*DW +: DW];
            end
        end
    end

    for (genvar g = 0; g < N_IN; g++) begin : g_rd
        logic [IN_W-1:0]   r_in;
        logic [SLOT_W-1:0] r_slot;
        assign r_in   = rd_in_i[g*IN_W +: IN_W];
        assign r_slot = rd_slot_i[g*SLOT_W +: SLOT_W];
        assign rd_data_o[g*DW +: DW] =
            slot_in_range(r_slot) ? mem[rd_bank][r_in][r_slot] : AIS_BYTE;
    end

endmodule

// File: rtl/tsi_conn_images.sv
module tsi_conn_images
    import tsi_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    frame_i,
    input  logic                    cfg_we_i,
    input  logic [IMG_W-1:0]        cfg_img_i,
    input  logic [IN_W-1:0]         cfg_port_i,
    input  logic [SLOT_W-1:0]       cfg_slot_i,
    input  logic [ENTRY_W-1:0]      cfg_entry_i,
    input  logic                    swap_req_i,
    input  logic [IMG_W-1:0]        swap_img_i,
    input  logic [SLOT_W-1:0]       rd_slot_i,
    output logic [N_IN*ENTRY_W-1:0] entries_o,
    output logic [IMG_W-1:0]        active_o,
    output logic                    pending_o,
    output logic [IMG_W-1:0]        pend_img_o
);

    conn_t            img [N_IMG][N_IN][N_SLOT];
    logic [IMG_W-1:0] act_q;
    logic [IMG_W-1:0] pimg_q;
    logic             pend_q;
    logic [IMG_W-1:0] steer_img;
    logic             take_swap;

    assign take_swap = frame_i && pend_q;
    assign steer_img = take_swap ? pimg_q : act_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int m = 0; m < N_IMG; m++) begin
                for (int o = 0; o < N_IN; o++) begin
                    for (int s = 0; s < N_SLOT; s++) begin
                        img[m][o][s] <= '0;
                    end
                end
            end
        end else if (cfg_we_i && slot_in_range(cfg_slot_i)) begin
            img[cfg_img_i][cfg_port_i][cfg_slot_i] <= conn_t'(cfg_entry_i);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q  <= '0;
            pimg_q <= '0;
            pend_q <= 1'b0;
        end else begin
            if (take_swap) begin
                act_q <= pimg_q;
            end
            if (swap_req_i) begin
                pend_q <= 1'b1;
                pimg_q <= swap_img_i;
            end else if (take_swap) begin
                pend_q <= 1'b0;
            end
        end
    end

    for (genvar g = 0; g < N_IN; g++) begin : g_sel
        assign entries_o[g*ENTRY_W +: ENTRY_W] =
            slot_in_range(rd_slot_i) ? img[steer_img][g][rd_slot_i] : '0;
    end

    assign active_o   = act_q;
    assign pending_o  = pend_q;
    assign pend_img_o = pimg_q;

endmodule

// File: rtl/tsi_frame_switch.sv
module tsi_frame_switch
    import tsi_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                frame_i,
    input  logic [N_IN*DW-1:0]  din_i,
    input  logic [N_IN-1:0]     fail_i,
    input  logic                cfg_we_i,
    input  logic [IMG_W-1:0]    cfg_img_i,
    input  logic [IN_W-1:0]     cfg_port_i,
    input  logic [SLOT_W-1:0]   cfg_slot_i,
    input  logic [ENTRY_W-1:0]  cfg_entry_i,
    input  logic                swap_req_i,
    input  logic [IMG_W-1:0]    swap_img_i,
    output logic                frame_o,
    output logic [N_IN*DW-1:0]  dout_o,
    output logic [IMG_W-1:0]    active_img_o,
    output logic                swap_pending_o
);

    logic [SLOT_W-1:0]        cur_slot;
    logic                     cur_bank;
    logic [N_IN*ENTRY_W-1:0]  entries;
    logic [N_IN*IN_W-1:0]     lane_src;
    logic [N_IN*SLOT_W-1:0]   lane_slot;
    logic [N_IN-1:0]          lane_use;
    logic [N_IN*DW-1:0]       rd_data;
    logic [N_IN*DW-1:0]       dout_d;
    logic [N_IN*DW-1:0]       dout_q;
    logic                     frame_q;
    logic [IMG_W-1:0]         pend_img;

    tsi_slot_timer u_timer (
        .clk        (clk),
        .rst        (rst),
        .frame_i    (frame_i),
        .cur_slot_o (cur_slot),
        .cur_bank_o (cur_bank)
    );

    tsi_conn_images u_images (
        .clk         (clk),
        .rst         (rst),
        .frame_i     (frame_i),
        .cfg_we_i    (cfg_we_i),
        .cfg_img_i   (cfg_img_i),
        .cfg_port_i  (cfg_port_i),
        .cfg_slot_i  (cfg_slot_i),
        .cfg_entry_i (cfg_entry_i),
        .swap_req_i  (swap_req_i),
        .swap_img_i  (swap_img_i),
        .rd_slot_i   (cur_slot),
        .entries_o   (entries),
        .active_o    (active_img_o),
        .pending_o   (swap_pending_o),
        .pend_img_o  (pend_img)
    );

    for (genvar g = 0; g < N_IN; g++) begin : g_lane
        conn_t ent;
        assign ent = conn_t'(entries[g*ENTRY_W +: ENTRY_W]);
        assign lane_use[g]                     = entry_usable(ent);
        assign lane_src[g*IN_W +: IN_W]        = ent.src_in;
        assign lane_slot[g*SLOT_W +: SLOT_W]   = ent.src_slot;
        assign dout_d[g*DW +: DW] =
            (lane_use[g] && !fail_i[ent.src_in]) ? rd_data[g*DW +: DW] : AIS_BYTE;
    end

    tsi_data_store u_store (
        .clk       (clk),
        .rst       (rst),
        .wr_bank_i (cur_bank),
        .wr_slot_i (cur_slot),
        .din_i     (din_i),
        .rd_in_i   (lane_src),
        .rd_slot_i (lane_slot),
        .rd_data_o (rd_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            dout_q  <= '1;
            frame_q <= 1'b0;
        end else begin
            dout_q  <= dout_d;
            frame_q <= frame_i;
        end
    end

    assign dout_o  = dout_q;
    assign frame_o = frame_q;

endmodule

// File: rtl/tsi_frame_switch_chk.sv
module tsi_frame_switch_chk
    import tsi_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                frame_i,
    input logic                swap_req_i,
    input logic [N_IN-1:0]     fail_i,
    input logic                frame_o,
    input logic [N_IN*DW-1:0]  dout_o,
    input logic [IMG_W-1:0]    active_img_o,
    input logic                swap_pending_o,
    input logic [IMG_W-1:0]    pend_img,
    input logic [N_IN-1:0]     lane_use,
    input logic [N_IN*IN_W-1:0] lane_src
);

    AST_FRAME_ECHO: assert property (@(posedge clk) disable iff (rst)
        frame_i |=> frame_o); // R2

    AST_REQ_SETS_PEND: assert property (@(posedge clk) disable iff (rst)
        swap_req_i |=> swap_pending_o); // R8

    AST_PEND_DROPS: assert property (@(posedge clk) disable iff (rst)
        (swap_pending_o && frame_i && !swap_req_i) |=> !swap_pending_o); // R8

    AST_SWAP_TARGET: assert property (@(posedge clk) disable iff (rst)
        (swap_pending_o && frame_i) |=> (active_img_o == $past(pend_img))); // R8

    AST_IMG_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(swap_pending_o && frame_i) |=> $stable(active_img_o)); // R9

    for (genvar g = 0; g < N_IN; g++) begin : g_lane_chk
        AST_UNUSED_AIS: assert property (@(posedge clk) disable iff (rst)
            !lane_use[g] |=> (dout_o[g*DW +: DW] == AIS_BYTE)); // R4

        AST_FAIL_AIS: assert property (@(posedge clk) disable iff (rst)
            fail_i[lane_src[g*IN_W +: IN_W]] |=> (dout_o[g*DW +: DW] == AIS_BYTE)); // R6
    end

endmodule

bind tsi_frame_switch tsi_frame_switch_chk u_chk (
    .clk            (clk),
    .rst            (rst),
    .frame_i        (frame_i),
    .swap_req_i     (swap_req_i),
    .fail_i         (fail_i),
    .frame_o        (frame_o),
    .dout_o         (dout_o),
    .active_img_o   (active_img_o),
    .swap_pending_o (swap_pending_o),
    .pend_img       (pend_img),
    .lane_use       (lane_use),
    .lane_src       (lane_src)
);

// File: tb/tsi_frame_switch_bench.sv
module tsi_frame_switch_bench;
    import tsi_pkg::*;

    logic        clk;
    logic        rst;
    logic        frame_i;
    logic [31:0] din_i;
    logic [3:0]  fail_i;
    logic        cfg_we_i;
    logic [1:0]  cfg_img_i;
    logic [1:0]  cfg_port_i;
    logic [3:0]  cfg_slot_i;
    logic [6:0]  cfg_entry_i;
    logic        swap_req_i;
    logic [1:0]  swap_img_i;
    logic        frame_o;
    logic [31:0] dout_o;
    logic [1:0]  active_img_o;
    logic        swap_pending_o;

    int total = 0;
    int bad   = 0;
    int fcnt  = 0;
    int flen  = 12;
    int dcnt  = 0;
    bit done  = 0;
    string phase = "R10";

    logic [7:0] m_mem [2][4][12];
    logic [6:0] m_img [4][4][12];
    int         m_slot, m_bank, m_act, m_pimg;
    bit         m_pend;
    logic [7:0] e_dout [4];
    string      e_tag  [4];
    logic       e_frame;

    tsi_frame_switch u_tsi_frame_switch (
        .clk(clk), .rst(rst), .frame_i(frame_i), .din_i(din_i), .fail_i(fail_i),
        .cfg_we_i(cfg_we_i), .cfg_img_i(cfg_img_i), .cfg_port_i(cfg_port_i),
        .cfg_slot_i(cfg_slot_i), .cfg_entry_i(cfg_entry_i),
        .swap_req_i(swap_req_i), .swap_img_i(swap_img_i),
        .frame_o(frame_o), .dout_o(dout_o), .active_img_o(active_img_o),
        .swap_pending_o(swap_pending_o)
    );

    initial clk = 1'b0;
    always #2 clk = ~clk;

    // Behavioural reference: predicts the registered outputs for the next cycle.
    always @(posedge clk) begin
        if (rst) begin
            for (int b = 0; b < 2; b++)
                for (int i = 0; i < 4; i++)
                    for (int s = 0; s < 12; s++) m_mem[b][i][s] = 8'hFF;
            for (int m = 0; m < 4; m++)
                for (int o = 0; o < 4; o++)
                    for (int s = 0; s < 12; s++) m_img[m][o][s] = 7'd0;
            m_slot = 11; m_bank = 0; m_act = 0; m_pimg = 0; m_pend = 0;
            for (int o = 0; o < 4; o++) begin e_dout[o] = 8'hFF; e_tag[o] = "R10"; end
            e_frame = 1'b0;
        end else begin : mdl
            int cs, cb, ra, src, sl;
            cs = frame_i ? 0 : ((m_slot == 11) ? 0 : m_slot + 1);
            cb = frame_i ? 1 - m_bank : m_bank;
            ra = (frame_i && m_pend) ? m_pimg : m_act;
            for (int o = 0; o < 4; o++) begin
                src = int'(m_img[ra][o][cs][5:4]);
                sl  = int'(m_img[ra][o][cs][3:0]);
                if (!m_img[ra][o][cs][6]) begin
                    e_dout[o] = 8'hFF; e_tag[o] = "R4";
                end else if (sl >= 12) begin
                    e_dout[o] = 8'hFF; e_tag[o] = "R5";
                end else if (fail_i[src]) begin
                    e_dout[o] = 8'hFF; e_tag[o] = "R6";
                end else begin
                    e_dout[o] = m_mem[1 - cb][src][sl]; e_tag[o] = phase;
                end
            end
            for (int i = 0; i < 4; i++) m_mem[cb][i][cs] = din_i[i*8 +: 8];
            if (cfg_we_i && cfg_slot_i < 4'd12)
                m_img[cfg_img_i][cfg_port_i][cfg_slot_i] = cfg_entry_i;
            if (frame_i && m_pend) begin m_act = m_pimg; m_pend = 0; end
            if (swap_req_i) begin m_pend = 1; m_pimg = int'(swap_img_i); end
            m_slot = cs; m_bank = cb; e_frame = frame_i;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h time=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        if (!done) begin
            for (int o = 0; o < 4; o++)
                chk(dout_o[o*8 +: 8] === e_dout[o], e_tag[o], int'(dout_o[o*8 +: 8]), int'(e_dout[o]));
            chk(frame_o === e_frame, "R2", int'(frame_o), int'(e_frame));
            chk(active_img_o === 2'(m_act), (phase == "R9") ? "R9" : "R8", int'(active_img_o), m_act);
            chk(swap_pending_o === m_pend, (phase == "R11") ? "R11" : "R8", int'(swap_pending_o), int'(m_pend));
        end
        cfg_we_i   = 1'b0;
        swap_req_i = 1'b0;
        frame_i    = (!rst) && (fcnt == 0);
        if (!rst) fcnt = (fcnt + 1 >= flen) ? 0 : fcnt + 1;
        dcnt++;
        for (int i = 0; i < 4; i++) din_i[i*8 +: 8] = 8'(dcnt * 13 + i * 57 + 3);
    endtask

    task automatic run(input int n);
        for (int k = 0; k < n; k++) tick();
    endtask

    function automatic logic [6:0] mk(input bit v, input int src, input int sl);
        return {v, 2'(src), 4'(sl)};
    endfunction

    task automatic wcfg(input int m, input int o, input int s, input logic [6:0] e);
        cfg_we_i = 1'b1; cfg_img_i = 2'(m); cfg_port_i = 2'(o);
        cfg_slot_i = 4'(s); cfg_entry_i = e;
        tick();
    endtask

    task automatic swap(input int m);
        swap_req_i = 1'b1; swap_img_i = 2'(m);
        tick();
    endtask

    initial begin
        #800000;
        if (!done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; frame_i = 1'b0; din_i = '0; fail_i = '0;
        cfg_we_i = 1'b0; cfg_img_i = '0; cfg_port_i = '0; cfg_slot_i = '0;
        cfg_entry_i = '0; swap_req_i = 1'b0; swap_img_i = '0;
        run(4);
        rst = 1'b0;
        run(14);

        // Active image 0 written live; lane 3 has an out-of-range and an empty slot.
        phase = "R2";
        for (int o = 0; o < 4; o++)
            for (int s = 0; s < 12; s++) begin
                if (o == 3 && s == 10) wcfg(0, o, s, mk(1, 2, 13));
                else if (!(o == 3 && s == 11)) wcfg(0, o, s, mk(1, o + s, (s * 5) % 12));
            end
        run(30);

        // Rewrite inactive image 2 while traffic runs; outputs stay on image 0.
        phase = "R7";
        for (int o = 0; o < 4; o++)
            for (int s = 0; s < 12; s++) wcfg(2, o, s, mk(1, 3 - o, 11 - s));
        wcfg(2, 0, 13, mk(1, 0, 0));
        run(20);

        phase = "R8";
        run(5);
        swap(2);
        run(30);

        phase = "R3";
        for (int o = 0; o < 4; o++) begin
            wcfg(1, o, 2, mk(1, 1, 4));
            wcfg(1, o, 6, mk(1, 1, 4));
            wcfg(1, o, 9, mk(1, 2, 0));
        end
        swap(1);
        run(30);

        phase = "R6";
        swap(2);
        run(14);
        fail_i = 4'b0101;
        run(15);
        fail_i = 4'b0000;
        run(14);

        phase = "R11";
        run(3);
        swap(0);
        run(2);
        swap(3);
        run(30);

        phase = "R1";
        swap(0);
        flen = 7;
        run(30);
        flen = 12;
        run(30);

        phase = "R9";
        for (int k = 0; k < 30 && frame_i !== 1'b1; k++) tick();
        swap(2);
        run(30);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule